// File: doc/BRIEF.md
# NAND flash bus interface controller

This block sits between a 32-bit register bus and an 8-bit NAND flash device. Software drives every flash cycle by hand: it sets the command-latch, address-latch and chip-enable levels in a mode register, then writes or reads a single data register. Each data access becomes one timed strobe on the flash bus. A programmable pulse width and a programmable hold time shape that strobe, and the register access is stalled until the whole strobe-plus-hold window has elapsed.

The flash ready/busy pin is synchronised and shown as a busy flag. A busy-to-ready transition latches an interrupt flag, which raises the interrupt output when it is unmasked. A self-clearing soft reset returns all programmable state to zero after a fixed number of clocks.

The bus is a simple request/acknowledge port. The host holds `bus_req` together with the address, direction and write data until `bus_ack` pulses for one clock; read data is valid in that same clock. The host then lowers `bus_req`.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, `nf_ce_n`, `nf_we_n` and `nf_re_n` are 1, `nf_dq_oe` is 0 and `irq` is 0.
- R2: Word offsets: data 0x00, mode 0x04, status 0x08, interrupt flag 0x0C, interrupt mask 0x10, timing 0x14, soft reset 0x18. Mode keeps bit 0 (command latch), bit 1 (address latch), bit 4 (chip enable) and bit 7 (write gate), and every other mode bit reads 0. Timing keeps the hold value in bits 7:4 and the strobe value in bits 3:0. Unmapped or misaligned offsets read 0, and writes to them change nothing.
- R3: `nf_cle` follows mode bit 0 and `nf_ale` follows mode bit 1. `nf_ce_n` is the inverse of mode bit 4.
- R4: A data write that is allowed to strobe holds `nf_we_n` low for strobe+1 clocks. Bits 7:0 of the write data are driven on `nf_dq_out`, with `nf_dq_oe` high. A hold of hold+2 clocks follows, and then `bus_ack` rises. From the first clock edge that sees the request, `bus_ack` is seen after strobe+hold+4 edges, including with both timing fields at 0.
- R5: A data write strobes only when the command latch, the address latch or the write gate bit is 1. Otherwise it is acknowledged one edge after acceptance and no strobe occurs.
- R6: A data read holds `nf_re_n` low for strobe+1 clocks and samples `nf_dq_in` at the end of the strobe. After the hold time it returns the sampled byte in bits 7:0, with bits 31:8 zero, and follows the same completion timing as R4.
- R7: Every access other than a strobing data access is acknowledged one edge after acceptance. `bus_ack` is never high for two clocks in a row.
- R8: Status bit 7 reads 1 while `nf_rb_n` is low and 0 while it is high, after a two-clock synchroniser.
- R9: Interrupt flag bit 0 sets on a busy-to-ready transition of the synchronised pin. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R10: `irq` is 1 exactly when interrupt flag bit 0 and mask bit 0 are both 1.
- R11: Writing 1 to soft-reset bit 0 starts a reset. During the reset that bit reads 1 for RST_CYCLES clocks. At the end it reads 0, and the mode, timing, flag and mask registers are all zero. Writing 0 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-clock completion pulse |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | FLASH_W | Data driven to the flash |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_out` |
| nf_dq_in | input | FLASH_W | Data from the flash |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0) |
| irq | output | 1 | Masked ready interrupt |

## Verification
Register accesses complete one edge after acceptance, and strobing data accesses complete strobe+hold+4 edges after the request is first seen. The bench counts edges from the moment it raises the request up to the falling-edge sample that shows `bus_ack`, and compares that count with the expected figure for each vector. The strobe width is taken by counting the falling-edge samples in which `nf_we_n` or `nf_re_n` is low. Ready-pin effects are sampled only after more clocks than the synchroniser depth, and soft-reset completion only after more than RST_CYCLES clocks.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    typedef enum logic [2:0] {
        RI_DATA   = 3'd0,
        RI_MODE   = 3'd1,
        RI_STAT   = 3'd2,
        RI_ISTAT  = 3'd3,
        RI_IMASK  = 3'd4,
        RI_TIMING = 3'd5,
        RI_SRST   = 3'd6,
        RI_NONE   = 3'd7
    } reg_idx_e;

    localparam int MB_CLE  = 0;
    localparam int MB_ALE  = 1;
    localparam int MB_CE   = 4;
    localparam int MB_WEG  = 7;
    localparam int SB_BUSY = 7;
    localparam int TB_HOLD = 4;

    typedef struct packed {
        logic wegate;
        logic ce;
        logic ale;
        logic cle;
    } mode_t;

    typedef enum logic [1:0] {
        SG_IDLE,
        SG_STROBE,
        SG_HOLD
    } sg_state_e;

    function automatic reg_idx_e decode_idx(input logic [7:0] off);
        if (off[1:0] != 2'b00 || off[7:5] != 3'b000 || off[4:2] == 3'd7)
            return RI_NONE;
        return reg_idx_e'(off[4:2]);
    endfunction

    function automatic logic [7:0] mode_byte(input mode_t m);
        logic [7:0] b;
        b = '0;
        b[MB_CLE] = m.cle;
        b[MB_ALE] = m.ale;
        b[MB_CE]  = m.ce;
        b[MB_WEG] = m.wegate;
        return b;
    endfunction

endpackage

// File: rtl/nbc_rb_sync.sv
module nbc_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_n_in,
    output logic ready,
    output logic ready_rise
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            prev <= 1'b1;
        end else begin
            sh   <= {sh[STAGES-2:0], rb_n_in};
            prev <= sh[STAGES-1];
        end
    end

    assign ready      = sh[STAGES-1];
    assign ready_rise = sh[STAGES-1] & ~prev;

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        ready_rise |=> !ready_rise);

endmodule

// File: rtl/nbc_regfile.sv
module nbc_regfile
    import nbc_pkg::*;
#(
    parameter int TIME_W     = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_idx_e          idx,
    input  logic [7:0]        wbyte,
    input  logic              ready_rise,
    output mode_t             mode,
    output logic [TIME_W-1:0] hold,
    output logic [TIME_W-1:0] spw,
    output logic              istat,
    output logic              imask,
    output logic              srst_busy
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic [RC_W-1:0] rcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= '0;
            hold      <= '0;
            spw       <= '0;
            istat     <= 1'b0;
            imask     <= 1'b0;
            srst_busy <= 1'b0;
            rcnt      <= '0;
        end else begin
            if (wr_en) begin
                case (idx)
                    RI_MODE: begin
                        mode.cle    <= wbyte[MB_CLE];
                        mode.ale    <= wbyte[MB_ALE];
                        mode.ce     <= wbyte[MB_CE];
                        mode.wegate <= wbyte[MB_WEG];
                    end
                    RI_TIMING: begin
                        hold <= wbyte[TB_HOLD +: TIME_W];
                        spw  <= wbyte[0 +: TIME_W];
                    end
                    RI_IMASK: imask <= wbyte[0];
                    RI_ISTAT: if (wbyte[0]) istat <= 1'b0;
                    RI_SRST: begin
                        if (wbyte[0] && !srst_busy) begin
                            srst_busy <= 1'b1;
                            rcnt      <= RC_W'(RST_CYCLES - 1);
                        end
                    end
                    default: ;
                endcase
            end
            if (ready_rise)
                istat <= 1'b1;
            if (srst_busy) begin
                if (rcnt == '0) begin
                    srst_busy <= 1'b0;
                    mode      <= '0;
                    hold      <= '0;
                    spw       <= '0;
                    istat     <= 1'b0;
                    imask     <= 1'b0;
                end else begin
                    rcnt <= rcnt - 1'b1;
                end
            end
        end
    end

    // R9
    flag_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_rise && !(srst_busy && rcnt == '0)) |=> istat);

    // R11
    srst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (srst_busy && rcnt == '0) |=> (!srst_busy && mode == '0 && hold == '0 && spw == '0 && !imask));

endmodule

// File: rtl/nbc_strobe_gen.sv
module nbc_strobe_gen
    import nbc_pkg::*;
#(
    parameter int TIME_W  = 4,
    parameter int FLASH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               start_read,
    input  logic [FLASH_W-1:0] wbyte,
    input  logic [TIME_W-1:0]  hold,
    input  logic [TIME_W-1:0]  spw,
    input  logic [FLASH_W-1:0] dq_in,
    output logic               we_n,
    output logic               re_n,
    output logic [FLASH_W-1:0] dq_out,
    output logic               dq_oe,
    output logic               busy,
    output logic               finish,
    output logic [FLASH_W-1:0] rd_byte
);
    localparam int CNT_W = TIME_W + 1;

    sg_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [TIME_W-1:0]  hold_q;
    logic               is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SG_IDLE;
            cnt     <= '0;
            hold_q  <= '0;
            is_rd   <= 1'b0;
            dq_out  <= '0;
            rd_byte <= '0;
        end else begin
            case (state)
                SG_IDLE: begin
                    if (start) begin
                        state  <= SG_STROBE;
                        cnt    <= CNT_W'(spw);
                        hold_q <= hold;
                        is_rd  <= start_read;
                        if (!start_read)
                            dq_out <= wbyte;
                    end
                end
                SG_STROBE: begin
                    if (cnt == '0) begin
                        state <= SG_HOLD;
                        cnt   <= CNT_W'(hold_q) + 1'b1;
                        if (is_rd)
                            rd_byte <= dq_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SG_HOLD: begin
                    if (cnt == '0)
                        state <= SG_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= SG_IDLE;
            endcase
        end
    end

    assign busy   = (state != SG_IDLE);
    assign finish = (state == SG_HOLD) && (cnt == '0);
    assign we_n   = !((state == SG_STROBE) && !is_rd);
    assign re_n   = !((state == SG_STROBE) && is_rd);
    assign dq_oe  = busy && !is_rd;

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    // R4
    strobe_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SG_STROBE && cnt != '0) |=> (state == SG_STROBE && cnt == $past(cnt) - 1'b1));

    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (state == SG_IDLE));

endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
    import nbc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int FLASH_W     = 8,
    parameter int TIME_W      = 4,
    parameter int RST_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_ack,
    output logic               nf_ce_n,
    output logic               nf_cle,
    output logic               nf_ale,
    output logic               nf_we_n,
    output logic               nf_re_n,
    output logic [FLASH_W-1:0] nf_dq_out,
    output logic               nf_dq_oe,
    input  logic [FLASH_W-1:0] nf_dq_in,
    input  logic               nf_rb_n,
    output logic               irq
);
    localparam int REG_BYTE = 8;

    reg_idx_e            idx;
    logic                accept;
    logic                is_data;
    logic                wr_may_strobe;
    logic                sg_start;
    logic                sg_busy;
    logic                sg_finish;
    logic [FLASH_W-1:0]  sg_rd_byte;
    mode_t               mode;
    logic [TIME_W-1:0]   hold;
    logic [TIME_W-1:0]   spw;
    logic                istat;
    logic                imask;
    logic                srst_busy;
    logic                ready;
    logic                ready_rise;
    logic                ack_q;
    logic [DATA_W-1:0]   rdata_q;
    logic [DATA_W-1:0]   rd_mux;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_BYTE];

    assign idx           = decode_idx(8'(bus_addr));
    assign accept        = bus_req && !ack_q && !sg_busy;
    assign is_data       = (idx == RI_DATA);
    assign wr_may_strobe = mode.cle || mode.ale || mode.wegate;
    assign sg_start      = accept && is_data && (!bus_wr || wr_may_strobe);

    nbc_rb_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst        (rst),
        .rb_n_in    (nf_rb_n),
        .ready      (ready),
        .ready_rise (ready_rise)
    );

    nbc_regfile #(
        .TIME_W     (TIME_W),
        .RST_CYCLES (RST_CYCLES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (accept && bus_wr),
        .idx        (idx),
        .wbyte      (bus_wdata[REG_BYTE-1:0]),
        .ready_rise (ready_rise),
        .mode       (mode),
        .hold       (hold),
        .spw        (spw),
        .istat      (istat),
        .imask      (imask),
        .srst_busy  (srst_busy)
    );

    nbc_strobe_gen #(
        .TIME_W  (TIME_W),
        .FLASH_W (FLASH_W)
    ) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .start      (sg_start),
        .start_read (!bus_wr),
        .wbyte      (bus_wdata[FLASH_W-1:0]),
        .hold       (hold),
        .spw        (spw),
        .dq_in      (nf_dq_in),
        .we_n       (nf_we_n),
        .re_n       (nf_re_n),
        .dq_out     (nf_dq_out),
        .dq_oe      (nf_dq_oe),
        .busy       (sg_busy),
        .finish     (sg_finish),
        .rd_byte    (sg_rd_byte)
    );

    always_comb begin
        rd_mux = '0;
        case (idx)
            RI_MODE:   rd_mux = DATA_W'(mode_byte(mode));
            RI_STAT:   rd_mux[SB_BUSY] = ~ready;
            RI_ISTAT:  rd_mux[0] = istat;
            RI_IMASK:  rd_mux[0] = imask;
            RI_TIMING: rd_mux = DATA_W'({hold, spw});
            RI_SRST:   rd_mux[0] = srst_busy;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= 1'b0;
            if (sg_finish) begin
                ack_q   <= 1'b1;
                rdata_q <= DATA_W'(sg_rd_byte);
            end else if (accept && !sg_start) begin
                ack_q   <= 1'b1;
                rdata_q <= bus_wr ? '0 : rd_mux;
            end
        end
    end

    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;
    assign nf_ce_n   = ~mode.ce;
    assign nf_cle    = mode.cle;
    assign nf_ale    = mode.ale;
    assign irq       = istat & imask;

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    // R4
    drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        !nf_we_n |-> nf_dq_oe);

endmodule

// File: tb/tb_nand_bus_ctrl.sv
module tb_nand_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, irq;
    logic [7:0]  nf_dq_out;
    logic [7:0]  nf_dq_in = '0;
    logic        nf_rb_n = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    nand_bus_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .nf_ce_n   (nf_ce_n),
        .nf_cle    (nf_cle),
        .nf_ale    (nf_ale),
        .nf_we_n   (nf_we_n),
        .nf_re_n   (nf_re_n),
        .nf_dq_out (nf_dq_out),
        .nf_dq_oe  (nf_dq_oe),
        .nf_dq_in  (nf_dq_in),
        .nf_rb_n   (nf_rb_n),
        .irq       (irq)
    );

    // {is_read, mode, hold, spw, byte, expected strobe clocks, expected edges to ack}
    localparam int NV = 7;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 8'h80, 4'd1,  4'd1,  8'hA5, 5'd2,  6'd6},
        {1'b0, 8'h01, 4'd3,  4'd2,  8'h70, 5'd3,  6'd9},
        {1'b0, 8'h02, 4'd15, 4'd15, 8'h3C, 5'd16, 6'd34},
        {1'b0, 8'h10, 4'd2,  4'd2,  8'hFF, 5'd0,  6'd1},
        {1'b1, 8'h10, 4'd1,  4'd4,  8'hC3, 5'd5,  6'd9},
        {1'b1, 8'h00, 4'd0,  4'd0,  8'h5A, 5'd1,  6'd4},
        {1'b0, 8'h80, 4'd0,  4'd0,  8'h01, 5'd1,  6'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge with the bus idle.
    task automatic xfer(input logic wr, input logic [4:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc, output int we_cnt,
                        output int re_cnt, output logic [7:0] dq_seen, output logic oe_bad);
        cyc = 0; we_cnt = 0; re_cnt = 0; dq_seen = '0; oe_bad = 1'b0; rd = '0;
        bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        while (cyc < 100) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (!nf_we_n) begin
                we_cnt++;
                dq_seen = nf_dq_out;
                if (!nf_dq_oe) oe_bad = 1'b1;
            end
            if (!nf_re_n) re_cnt++;
            if (bus_ack) begin
                rd = bus_rdata;
                break;
            end
        end
        bus_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [4:0] addr, input logic [31:0] wd);
        logic [31:0] rd; int c, w, r; logic [7:0] q; logic ob;
        xfer(1'b1, addr, wd, rd, c, w, r, q, ob);
    endtask

    task automatic rd_reg(input logic [4:0] addr, output logic [31:0] rd);
        int c, w, r; logic [7:0] q; logic ob;
        xfer(1'b0, addr, '0, rd, c, w, r, q, ob);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state at pins and registers
        chk("R1 ce_n", 32'(nf_ce_n), 32'd1);
        chk("R1 we_n/re_n", 32'({nf_we_n, nf_re_n}), 32'd3);
        chk("R1 oe/irq", 32'({nf_dq_oe, irq}), 32'd0);
        for (int a = 1; a < 7; a++) begin
            rd_reg(5'(a * 4), rd);
            chk("R1 register zero", rd, 32'd0);
        end

        // Vector table: R3, R4, R5, R6
        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            logic [31:0] rdv; int c, w, r; logic [7:0] q; logic ob;
            v = VEC[i];
            wr_reg(5'h04, 32'(v[34:27]));
            wr_reg(5'h14, 32'({v[26:23], v[22:19]}));
            chk("R3 cle", 32'(nf_cle), 32'(v[27]));
            chk("R3 ale", 32'(nf_ale), 32'(v[28]));
            chk("R3 ce_n", 32'(nf_ce_n), 32'(!v[31]));
            nf_dq_in = v[18:11];
            xfer(!v[35], 5'h00, {24'hABCDEF, v[18:11]}, rdv, c, w, r, q, ob);
            nf_dq_in = '0;
            if (v[35]) begin
                chk("R6 read strobe clocks", 32'(r), 32'(v[10:6]));
                chk("R6 no write strobe", 32'(w), 32'd0);
                chk("R6 edges to ack", 32'(c), 32'(v[5:0]));
                chk("R6 read data", rdv, 32'(v[18:11]));
            end else if (v[10:6] == 0) begin
                chk("R5 gated write strobes", 32'(w + r), 32'd0);
                chk("R5 gated write edges", 32'(c), 32'd1);
            end else begin
                chk("R4 write strobe clocks", 32'(w), 32'(v[10:6]));
                chk("R4 no read strobe", 32'(r), 32'd0);
                chk("R4 edges to ack", 32'(c), 32'(v[5:0]));
                chk("R4 byte driven", 32'(q), 32'(v[18:11]));
                chk("R4 drive enabled", 32'(ob), 32'd0);
            end
        end

        // R2: readback masks and unmapped offsets
        wr_reg(5'h04, 32'hFFFF_FFFF);
        rd_reg(5'h04, rd);
        chk("R2 mode readback", rd, 32'h93);
        wr_reg(5'h14, 32'h0000_01AB);
        rd_reg(5'h14, rd);
        chk("R2 timing readback", rd, 32'hAB);
        rd_reg(5'h1C, rd);
        chk("R2 unmapped read", rd, 32'd0);
        wr_reg(5'h06, 32'h0);
        rd_reg(5'h04, rd);
        chk("R2 misaligned write ignored", rd, 32'h93);

        // R7: register access completes one edge after acceptance
        begin
            logic [31:0] rdv; int c, w, r; logic [7:0] q; logic ob;
            xfer(1'b0, 5'h10, '0, rdv, c, w, r, q, ob);
            chk("R7 register edges to ack", 32'(c), 32'd1);
        end

        // R8: busy status
        nf_rb_n = 1'b0;
        repeat (4) @(negedge clk);
        rd_reg(5'h08, rd);
        chk("R8 busy while pin low", rd, 32'h80);
        rd_reg(5'h0C, rd);
        chk("R9 no flag while busy", rd, 32'd0);
        nf_rb_n = 1'b1;
        repeat (4) @(negedge clk);
        rd_reg(5'h08, rd);
        chk("R8 ready while pin high", rd, 32'd0);

        // R9/R10: flag, mask, write-one-to-clear
        rd_reg(5'h0C, rd);
        chk("R9 flag set on ready", rd, 32'd1);
        chk("R10 irq masked", 32'(irq), 32'd0);
        wr_reg(5'h10, 32'd1);
        chk("R10 irq unmasked", 32'(irq), 32'd1);
        wr_reg(5'h0C, 32'd0);
        rd_reg(5'h0C, rd);
        chk("R9 write 0 keeps flag", rd, 32'd1);
        wr_reg(5'h0C, 32'd1);
        rd_reg(5'h0C, rd);
        chk("R9 write 1 clears flag", rd, 32'd0);
        chk("R10 irq after clear", 32'(irq), 32'd0);

        // R11: soft reset
        nf_rb_n = 1'b0;
        repeat (4) @(negedge clk);
        nf_rb_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 irq before soft reset", 32'(irq), 32'd1);
        wr_reg(5'h18, 32'd0);
        rd_reg(5'h18, rd);
        chk("R11 write 0 no effect", rd, 32'd0);
        rd_reg(5'h04, rd);
        chk("R11 mode kept after write 0", rd, 32'h93);
        wr_reg(5'h18, 32'd1);
        rd_reg(5'h18, rd);
        chk("R11 reset bit reads 1", rd, 32'd1);
        repeat (8) @(negedge clk);
        rd_reg(5'h18, rd);
        chk("R11 reset bit self-clears", rd, 32'd0);
        rd_reg(5'h04, rd);
        chk("R11 mode cleared", rd, 32'd0);
        rd_reg(5'h14, rd);
        chk("R11 timing cleared", rd, 32'd0);
        rd_reg(5'h0C, rd);
        chk("R11 flag cleared", rd, 32'd0);
        rd_reg(5'h10, rd);
        chk("R11 mask cleared", rd, 32'd0);
        chk("R11 ce_n high", 32'(nf_ce_n), 32'd1);
        chk("R11 irq low", 32'(irq), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule